// File: doc/BRIEF.md
# Parity Error Capture Registers with Freeze-on-First-Fault

This block watches the read data of two groups of on-chip memories and records parity failures for software to inspect. The instruction group is a 72-bit word judged as four independent 18-bit slices. The scratch group is a 36-bit word judged as two 18-bit slices, together with one map-memory word that has its own parity line. Parity is odd: each slice, XOR-ed together with its parity bit, must give 1. A slice whose bits XOR to 0 is an error.

Each group owns one capture register. A capture register accepts new error bits only while it is empty. Once any bit is set it freezes, so the first failure in that group stays visible until software clears it. A load through the write port clears both registers and rewrites the low control field. An error that arrives in the same cycle as a load is still captured, so no fault is lost. Memories are read implicitly while idle, so by default parity is judged on every cycle whether or not a read strobe is present. Setting `IDLE_CHECK` to 0 limits checking to cycles that carry a strobe.

The status word places the instruction-slice flags at bits 10..7, the scratch-slice flags at bits 6..5, the map flag at bit 4 and the control field at bits 3..0.

Top module: `par_cap_top`

## Requirements
- R1: An instruction-memory slice k (data bits 18k+17..18k) whose 18 data bits XOR-ed with `im_par[k]` give 0 sets status bit 10-k. Slice 0 is bit 10 and slice 3 is bit 7. A slice that XORs to 1 sets nothing.
- R2: A scratch slice k (k = 0,1) that fails odd parity with `sm_par[k]` sets status bit 6-k. A map word that fails odd parity with `map_par` sets status bit 4.
- R3: A capture register that holds any error bit keeps its contents unchanged while no load occurs. New failures in its group add no bits.
- R4: The two groups freeze independently. A held instruction error does not block capture of scratch or map errors, and a held scratch or map error does not block capture of instruction errors.
- R5: A load (`ld`=1) clears every error bit and writes `ld_ctrl` into status bits 3..0. Without a load, bits 3..0 keep their value.
- R6: When a load coincides with a new parity failure, the status after that edge holds exactly the new failure bits.
- R7: Several instruction slices failing in the same cycle are captured together in one register update.
- R8: With `IDLE_CHECK`=1 (the default), failures are captured even when the read strobes are low.
- R9: `any_err` is 1 exactly when at least one error bit of the status word is set. It is 0 in the cycle after a load that saw no new failure.
- R10: After synchronous reset the status word is 0 and `any_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| im_rd | input | 1 | Instruction memory read strobe |
| im_data | input | 72 | Instruction memory read data |
| im_par | input | 4 | Instruction memory parity, one bit per slice |
| sm_rd | input | 1 | Scratch/data memory read strobe |
| sm_data | input | 36 | Scratch/data memory read data |
| sm_par | input | 2 | Scratch/data memory parity, one bit per slice |
| map_rd | input | 1 | Map memory read strobe |
| map_data | input | 18 | Map memory read data |
| map_par | input | 1 | Map memory parity |
| ld | input | 1 | Load strobe: clears errors and writes the control field |
| ld_ctrl | input | 4 | Value written to the control field on a load |
| stat_word | output | 11 | Status word: error flags and control field |
| any_err | output | 1 | High while any error flag is set |

## Verification
A failing read presented in one cycle shows up in `stat_word` and `any_err` right after the next rising edge, because the checkers feed the capture flops directly. A load takes effect after the same single edge. The bench changes its inputs at falling edges and samples outputs at the following falling edge, half a period after the capturing edge, so every check looks at the cycle in which the result is due. The sweeps cover all 16 instruction failure patterns and all 8 scratch/map patterns, each followed by a clearing load. Further short sequences cover freezing, group independence, load-versus-fault collisions and strobe-less capture.

// File: rtl/par_cap_pkg.sv
package par_cap_pkg;

  // Status bit of instruction slice k: slice 0 is the most significant flag.
  function automatic int im_bit(input int ctrl_w, input int sm_n, input int im_n, input int k);
    return ctrl_w + 1 + sm_n + im_n - 1 - k;
  endfunction

  // Status bit of scratch slice k: slice 0 sits just below the instruction flags.
  function automatic int sm_bit(input int ctrl_w, input int sm_n, input int k);
    return ctrl_w + 1 + sm_n - 1 - k;
  endfunction

  // Status bit of the map flag: directly above the control field.
  function automatic int map_bit(input int ctrl_w);
    return ctrl_w;
  endfunction

endpackage

// File: rtl/par_slice_chk.sv
module par_slice_chk #(
  parameter int NSLICE     = 4,
  parameter int SLICE_W    = 18,
  parameter int IDLE_CHECK = 1
) (
  input  logic                        rd,
  input  logic [NSLICE*SLICE_W-1:0]   data,
  input  logic [NSLICE-1:0]           par,
  output logic [NSLICE-1:0]           bad
);
  localparam logic GATE = (IDLE_CHECK == 0);

  logic chk_en;
  assign chk_en = rd | ~GATE;

  for (genvar k = 0; k < NSLICE; k++) begin : g_slice
    // odd parity: a slice plus its parity bit must XOR to 1
    assign bad[k] = chk_en & ~(^{data[k*SLICE_W +: SLICE_W], par[k]});
  end
endmodule

// File: rtl/par_freeze_reg.sv
module par_freeze_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)
      q <= '0;
    else if (clr || (q == '0))
      q <= din;
  end

  // R3: a non-empty register holds while no clear arrives
  assert_hold_frozen_R3: assert property (@(posedge clk) disable iff (rst)
    (!clr && (q != '0)) |=> $stable(q));

  // R6: a clear cycle captures exactly the failures presented with it
  assert_clear_captures_R6: assert property (@(posedge clk) disable iff (rst)
    clr |=> (q == $past(din)));

  // R3: an empty register never holds bits that were not presented
  assert_empty_takes_input_R3: assert property (@(posedge clk) disable iff (rst)
    (q == '0) |=> ((q & ~$past(din)) == '0));
endmodule

// File: rtl/par_cap_top.sv
module par_cap_top #(
  parameter int SLICE_W    = 18,
  parameter int IM_SLICES  = 4,
  parameter int SM_SLICES  = 2,
  parameter int MAP_W      = 18,
  parameter int CTRL_W     = 4,
  parameter int IDLE_CHECK = 1,
  localparam int IM_W      = IM_SLICES * SLICE_W,
  localparam int SM_W      = SM_SLICES * SLICE_W,
  localparam int SG_W      = SM_SLICES + 1,
  localparam int STAT_W    = CTRL_W + SG_W + IM_SLICES
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 im_rd,
  input  logic [IM_W-1:0]      im_data,
  input  logic [IM_SLICES-1:0] im_par,
  input  logic                 sm_rd,
  input  logic [SM_W-1:0]      sm_data,
  input  logic [SM_SLICES-1:0] sm_par,
  input  logic                 map_rd,
  input  logic [MAP_W-1:0]     map_data,
  input  logic                 map_par,
  input  logic                 ld,
  input  logic [CTRL_W-1:0]    ld_ctrl,
  output logic [STAT_W-1:0]    stat_word,
  output logic                 any_err
);
  import par_cap_pkg::*;

  logic [IM_SLICES-1:0] im_bad, im_q;
  logic [SM_SLICES-1:0] sm_bad;
  logic                 map_bad;
  logic [SG_W-1:0]      sg_bad, sg_q;
  logic [CTRL_W-1:0]    ctrl_q;

  par_slice_chk #(.NSLICE(IM_SLICES), .SLICE_W(SLICE_W), .IDLE_CHECK(IDLE_CHECK)) u_im_chk (
    .rd(im_rd), .data(im_data), .par(im_par), .bad(im_bad));

  par_slice_chk #(.NSLICE(SM_SLICES), .SLICE_W(SLICE_W), .IDLE_CHECK(IDLE_CHECK)) u_sm_chk (
    .rd(sm_rd), .data(sm_data), .par(sm_par), .bad(sm_bad));

  par_slice_chk #(.NSLICE(1), .SLICE_W(MAP_W), .IDLE_CHECK(IDLE_CHECK)) u_map_chk (
    .rd(map_rd), .data(map_data), .par(map_par), .bad(map_bad));

  // scratch group: scratch slices in the low bits, map flag on top
  assign sg_bad = {map_bad, sm_bad};

  par_freeze_reg #(.W(IM_SLICES)) u_im_reg (
    .clk(clk), .rst(rst), .clr(ld), .din(im_bad), .q(im_q));

  par_freeze_reg #(.W(SG_W)) u_sg_reg (
    .clk(clk), .rst(rst), .clr(ld), .din(sg_bad), .q(sg_q));

  always_ff @(posedge clk) begin
    if (rst)
      ctrl_q <= '0;
    else if (ld)
      ctrl_q <= ld_ctrl;
  end

  // status word assembly: every bit comes straight from a flop
  assign stat_word[CTRL_W-1:0]      = ctrl_q;
  assign stat_word[map_bit(CTRL_W)] = sg_q[SM_SLICES];
  for (genvar k = 0; k < SM_SLICES; k++) begin : g_sm_map
    assign stat_word[sm_bit(CTRL_W, SM_SLICES, k)] = sg_q[k];
  end
  for (genvar k = 0; k < IM_SLICES; k++) begin : g_im_map
    assign stat_word[im_bit(CTRL_W, SM_SLICES, IM_SLICES, k)] = im_q[k];
  end

  assign any_err = (|im_q) | (|sg_q);

  // R5: a load writes the control field
  assert_ctrl_load_R5: assert property (@(posedge clk) disable iff (rst)
    ld |=> (stat_word[CTRL_W-1:0] == $past(ld_ctrl)));

  // R5: without a load the control field is kept
  assert_ctrl_keep_R5: assert property (@(posedge clk) disable iff (rst)
    !ld |=> $stable(stat_word[CTRL_W-1:0]));

  // R9: summary matches the error flags of the status word
  assert_summary_R9: assert property (@(posedge clk) disable iff (rst)
    any_err == (stat_word[STAT_W-1:CTRL_W] != '0));

  // R4: a frozen instruction register does not stop scratch capture
  assert_group_indep_R4: assert property (@(posedge clk) disable iff (rst)
    ((im_q != '0) && (sg_q == '0) && !ld) |=> (sg_q == $past(sg_bad)));
endmodule

// File: tb/sim_par_cap_top.sv
module sim_par_cap_top;
  localparam int PERIOD = 10;
  localparam int SW = 18;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        im_rd = 1'b0, sm_rd = 1'b0, map_rd = 1'b0;
  logic [71:0] im_data = '0;
  logic [3:0]  im_par = '1;
  logic [35:0] sm_data = '0;
  logic [1:0]  sm_par = '1;
  logic [17:0] map_data = '0;
  logic        map_par = 1'b1;
  logic        ld = 1'b0;
  logic [3:0]  ld_ctrl = '0;
  logic [10:0] stat_word;
  logic        any_err;

  int n_run = 0, n_fail = 0;
  logic [3:0] exp_ctrl = '0;

  par_cap_top u0 (
    .clk(clk), .rst(rst), .im_rd(im_rd), .im_data(im_data), .im_par(im_par),
    .sm_rd(sm_rd), .sm_data(sm_data), .sm_par(sm_par),
    .map_rd(map_rd), .map_data(map_data), .map_par(map_par),
    .ld(ld), .ld_ctrl(ld_ctrl), .stat_word(stat_word), .any_err(any_err));

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [10:0] exp_word(input logic [3:0] ip, input logic [2:0] sp,
                                           input logic [3:0] c);
    logic [10:0] w = {7'd0, c};
    for (int k = 0; k < 4; k++) if (ip[k]) w[10-k] = 1'b1;
    for (int k = 0; k < 2; k++) if (sp[k]) w[6-k] = 1'b1;
    if (sp[2]) w[4] = 1'b1;
    return w;
  endfunction

  // present data with failing slices chosen by ip (instruction) and sp (scratch, map)
  task automatic drive(input logic [3:0] ip, input logic [2:0] sp, input logic strobe);
    for (int k = 0; k < 4; k++) begin
      logic [SW-1:0] d = SW'($urandom);
      im_data[k*SW +: SW] = d;
      im_par[k] = ip[k] ? ^d : ~^d;
    end
    for (int k = 0; k < 2; k++) begin
      logic [SW-1:0] d = SW'($urandom);
      sm_data[k*SW +: SW] = d;
      sm_par[k] = sp[k] ? ^d : ~^d;
    end
    map_data = SW'($urandom);
    map_par  = sp[2] ? ^map_data : ~^map_data;
    im_rd = strobe; sm_rd = strobe; map_rd = strobe;
  endtask

  task automatic chk(input string req, input logic [10:0] got, input logic [10:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %o expected %o", req, got, exp);
    end
  endtask

  // one clearing load carrying a new control value, no new failures
  task automatic clear_with(input logic [3:0] c);
    drive(4'd0, 3'd0, 1'b0);
    ld = 1'b1; ld_ctrl = c;
    @(negedge clk);
    ld = 1'b0;
    exp_ctrl = c;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk("R10 stat", stat_word, 11'd0);
    chk("R10 any", {10'd0, any_err}, 11'd0);

    // R1, R7, R9: every instruction failure pattern
    for (int p = 0; p < 16; p++) begin
      drive(4'(p), 3'd0, 1'b1);
      @(negedge clk);
      chk("R1/R7 im pattern", stat_word, exp_word(4'(p), 3'd0, exp_ctrl));
      chk("R9 any", {10'd0, any_err}, {10'd0, p != 0});
      clear_with(4'(p));
      chk("R5 clear+ctrl", stat_word, exp_word(4'd0, 3'd0, 4'(p)));
      chk("R9 low after clear", {10'd0, any_err}, 11'd0);
    end

    // R2: every scratch/map failure pattern
    for (int s = 0; s < 8; s++) begin
      drive(4'd0, 3'(s), 1'b1);
      @(negedge clk);
      chk("R2 sm/map pattern", stat_word, exp_word(4'd0, 3'(s), exp_ctrl));
      chk("R9 any", {10'd0, any_err}, {10'd0, s != 0});
      clear_with(4'(15 - s));
      chk("R5 clear+ctrl", stat_word, exp_word(4'd0, 3'd0, 4'(15 - s)));
    end

    // R3: instruction register frozen by slice 0
    drive(4'b0001, 3'd0, 1'b1);
    @(negedge clk);
    drive(4'b0100, 3'd0, 1'b1);
    @(negedge clk);
    drive(4'b1110, 3'd0, 1'b1);
    @(negedge clk);
    chk("R3 im frozen", stat_word, exp_word(4'b0001, 3'd0, exp_ctrl));

    // R4: scratch still captures while instruction is frozen
    drive(4'd0, 3'b010, 1'b1);
    @(negedge clk);
    chk("R4 sm under im freeze", stat_word, exp_word(4'b0001, 3'b010, exp_ctrl));
    // R3: scratch group now frozen, map failure ignored
    drive(4'd0, 3'b100, 1'b1);
    @(negedge clk);
    drive(4'd0, 3'd0, 1'b0);
    @(negedge clk);
    chk("R3 sm frozen", stat_word, exp_word(4'b0001, 3'b010, exp_ctrl));
    clear_with(4'b1010);

    // R4: instruction captures while scratch group is frozen
    drive(4'd0, 3'b100, 1'b1);
    @(negedge clk);
    drive(4'b1000, 3'b001, 1'b1);
    @(negedge clk);
    chk("R4 im under sm freeze", stat_word, exp_word(4'b1000, 3'b100, exp_ctrl));

    // R6: load coinciding with new failures keeps the new ones
    drive(4'b0110, 3'b001, 1'b1);
    ld = 1'b1; ld_ctrl = 4'b0101;
    @(negedge clk);
    ld = 1'b0; exp_ctrl = 4'b0101;
    drive(4'd0, 3'd0, 1'b0);
    chk("R6 clear+fault", stat_word, exp_word(4'b0110, 3'b001, exp_ctrl));
    chk("R6 any", {10'd0, any_err}, 11'd1);
    clear_with(4'b0011);

    // R8: failures with strobes low are still captured
    drive(4'b0010, 3'b101, 1'b0);
    @(negedge clk);
    chk("R8 idle capture", stat_word, exp_word(4'b0010, 3'b101, exp_ctrl));
    clear_with(4'b0000);
    chk("R5 final clear", stat_word, 11'd0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule